// File: doc/BRIEF.md
# Receive FIFO With Packet Alarm

This block buffers incoming data from a transfer engine and hands it to a host DMA channel. Data arrives one 16-bit halfword at a time on a valid/ready write stream and leaves as 32-bit words on a valid/ready read stream. Two halfwords make one word. The older halfword goes in the low half.

An alarm output goes high whenever the number of halfwords held is greater than a threshold set by software. Software normally sets the threshold to twice the packet size counted in words, for example 16 halfwords for an 8-word packet. The alarm then means that at least one whole packet is waiting, and the DMA channel reads one packet each time the alarm is seen.

The write stream stalls when the FIFO is full, and the transfer engine pauses on the full flag. A control input that is active low holds the FIFO empty. A receive-enable input gates every read. A half-drain mode lets the host read out the halfwords left below the threshold after a transfer ends, one halfword per beat. A read attempt that finds too little data returns zero and sets a sticky underflow flag.

Back-pressure rules:
- On the write side, a halfword is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` does not depend on `wr_valid`.
- On the read side, a beat is consumed on a rising edge where `rd_valid` and `rd_ready` are both high. `rd_valid` does not depend on `rd_ready`.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After `rst_n` is low, or after any rising edge with `clr_n` low, the outputs read as follows: `level` is 0, `empty` is 1, `full` is 0, `alarm` is 0 for any threshold, and `underflow` is 0. While `clr_n` is low, `wr_ready` and `rd_valid` are both 0.
- R2: `wr_ready` is 1 exactly when `clr_n` is 1 and `level` is below DEPTH_HW. Each accepted halfword raises `level` by one on the same edge.
- R3: `full` is 1 exactly when `level` equals DEPTH_HW. While full, no write is accepted and `level` never exceeds DEPTH_HW.
- R4: Word mode (`half_drain` = 0):
  - `rd_valid` is 1 when `clr_n` and `rx_en` are 1 and `level` is at least 2.
  - `rd_data` has the oldest halfword in bits [15:0] and the next oldest in bits [31:16].
  - An accepted read lowers `level` by 2.
- R5: Half-drain mode (`half_drain` = 1):
  - `rd_valid` is 1 when `clr_n` and `rx_en` are 1 and `level` is at least 1.
  - `rd_data` has the oldest halfword in bits [15:0] and zero in bits [31:16].
  - An accepted read lowers `level` by 1.
- R6: While `rx_en` is 0, `rd_valid` is 0 and `rd_ready` has no effect: `level` and `underflow` stay the same.
- R7: `alarm` is 1 exactly when `level` is strictly greater than `alarm_thr`.
- R8: `rd_data` is zero whenever `rd_valid` is 0. A rising edge with `clr_n` = 1, `rx_en` = 1, `rd_ready` = 1 and `rd_valid` = 0 sets `underflow` and leaves `level` unchanged. `underflow` stays set until `clr_n` is low at a rising edge.
- R9: When a write and a read are accepted on the same edge, `level` becomes the old level plus one minus the halfwords read.
- R10: Halfwords leave in the order they arrived, including across the wrap of the storage, and in any mix of word and half-drain reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_n | input | 1 | Soft clear, active low, sampled on the clock; holds the FIFO empty |
| rx_en | input | 1 | Receive enable; must be 1 for any read |
| half_drain | input | 1 | 0: 32-bit word reads; 1: one halfword per read |
| alarm_thr | input | LW | Alarm threshold in halfwords |
| wr_valid | input | 1 | Write halfword valid |
| wr_ready | output | 1 | FIFO can take a halfword |
| wr_data | input | HALF_W | Write halfword |
| rd_valid | output | 1 | Read beat available |
| rd_ready | input | 1 | DMA takes the read beat |
| rd_data | output | 2*HALF_W | Read data |
| full | output | 1 | Level equals DEPTH_HW |
| empty | output | 1 | Level is zero |
| level | output | LW | Fill level in halfwords |
| alarm | output | 1 | Level above threshold |
| underflow | output | 1 | Sticky flag for a read attempt with too little data |

LW is $clog2(DEPTH_HW+1).

## Verification
The hardest situations to reach from the ports are the ones at the edges of the storage:
- the full boundary together with a simultaneous read;
- a pointer wrap in the middle of a word read, where the low half sits in the last cell and the high half in the first;
- an odd level left over, where a word read must be refused while a halfword read is still allowed.

The stimulus runs in phases with different biases. Some phases favour writes and fill the FIFO to full; others favour word reads. Both keep an odd halfword count from time to time, so the read pointer keeps moving against the storage wrap. Directed steps add the remaining cases:
- threshold values on either side of the current level;
- read attempts on a nearly empty FIFO;
- reads held off by `rx_en`;
- a soft clear in the middle of the stream.

// File: rtl/rx_pkt_fifo_pkg.sv
package rx_pkt_fifo_pkg;
  typedef enum logic {
    RD_WORD = 1'b0,
    RD_HALF = 1'b1
  } rd_mode_e;

  function automatic logic [1:0] beat_cost(rd_mode_e m);
    return (m == RD_HALF) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/rxf_hw_store.sv
module rxf_hw_store #(
  parameter int HALF_W = 16,
  parameter int DEPTH_HW = 32,
  localparam int AW = $clog2(DEPTH_HW)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [HALF_W-1:0] rdata_lo,
  output logic [HALF_W-1:0] rdata_hi
);
  logic [HALF_W-1:0] cells [DEPTH_HW];
  logic [AW-1:0]     raddr_nxt;

  for (genvar i = 0; i < DEPTH_HW; i++) begin : g_cell
    logic [HALF_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(i))) cell_q <= wdata;
    end
    assign cells[i] = cell_q;
  end

  assign raddr_nxt = raddr + AW'(1);
  assign rdata_lo  = cells[raddr];
  assign rdata_hi  = cells[raddr_nxt];
endmodule

// File: rtl/rxf_occupancy.sv
module rxf_occupancy #(
  parameter int DEPTH_HW = 32,
  localparam int AW = $clog2(DEPTH_HW),
  localparam int LW = $clog2(DEPTH_HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          push,
  input  logic [1:0]    pop_cnt,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (!clr_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + AW'(1);
      rptr_q  <= rptr_q + AW'(pop_cnt);
      level_q <= level_q + LW'(push) - LW'(pop_cnt);
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign level = level_q;
endmodule

// File: rtl/rxf_drain_port.sv
module rxf_drain_port
  import rx_pkt_fifo_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DEPTH_HW = 32,
  localparam int LW = $clog2(DEPTH_HW + 1),
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              rx_en,
  input  rd_mode_e          mode,
  input  logic [LW-1:0]     level,
  input  logic [HALF_W-1:0] lo_half,
  input  logic [HALF_W-1:0] hi_half,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        pop_cnt,
  output logic              underflow
);
  logic [1:0] need;
  logic       enough;
  logic       armed;
  logic       underflow_q;

  assign need     = beat_cost(mode);
  assign enough   = level >= LW'(need);
  assign armed    = clr_n && rx_en;
  assign rd_valid = armed && enough;
  assign pop_cnt  = (rd_valid && rd_ready) ? need : 2'd0;

  always_comb begin
    rd_data = '0;
    if (rd_valid) begin
      rd_data[HALF_W-1:0] = lo_half;
      if (mode == RD_WORD) rd_data[WORD_W-1:HALF_W] = hi_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow_q <= 1'b0;
    else if (!clr_n) underflow_q <= 1'b0;
    else if (armed && rd_ready && !enough) underflow_q <= 1'b1;
  end

  assign underflow = underflow_q;
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_pkt_fifo_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DEPTH_HW = 32,
  localparam int AW = $clog2(DEPTH_HW),
  localparam int LW = $clog2(DEPTH_HW + 1),
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              rx_en,
  input  logic              half_drain,
  input  logic [LW-1:0]     alarm_thr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [HALF_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [LW-1:0]     level,
  output logic              alarm,
  output logic              underflow
);
  logic [AW-1:0]     wptr, rptr;
  logic [LW-1:0]     level_w;
  logic [1:0]        pop_cnt;
  logic [HALF_W-1:0] lo_half, hi_half;
  logic              push;
  rd_mode_e          mode;

  assign mode     = half_drain ? RD_HALF : RD_WORD;
  assign full     = level_w == LW'(DEPTH_HW);
  assign empty    = level_w == '0;
  assign wr_ready = clr_n && !full;
  assign push     = wr_valid && wr_ready;
  assign alarm    = level_w > alarm_thr;
  assign level    = level_w;

  rxf_occupancy #(.DEPTH_HW(DEPTH_HW)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .push(push),
    .pop_cnt(pop_cnt), .wptr(wptr), .rptr(rptr), .level(level_w)
  );

  rxf_hw_store #(.HALF_W(HALF_W), .DEPTH_HW(DEPTH_HW)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata_lo(lo_half), .rdata_hi(hi_half)
  );

  rxf_drain_port #(.HALF_W(HALF_W), .DEPTH_HW(DEPTH_HW)) u_drain (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rx_en(rx_en), .mode(mode),
    .level(level_w), .lo_half(lo_half), .hi_half(hi_half),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .pop_cnt(pop_cnt), .underflow(underflow)
  );
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int HALF_W = 16,
  parameter int DEPTH_HW = 32,
  localparam int LW = $clog2(DEPTH_HW + 1),
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              rx_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic              full,
  input logic [LW-1:0]     level,
  input logic              underflow
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (level == '0 && !underflow));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && wr_valid && wr_ready && !(rd_valid && rd_ready))
      |=> level == LW'($past(level) + LW'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH_HW));

  assert_rx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !wr_valid && clr_n) |=> $stable(level) && $stable(underflow));

  assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && clr_n) |=> underflow);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.HALF_W(HALF_W), .DEPTH_HW(DEPTH_HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rx_en(rx_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .full(full), .level(level),
  .underflow(underflow)
);

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 16;
  localparam int DEPTH_HW = 32;
  localparam int LW = $clog2(DEPTH_HW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1, rx_en = 1'b0, half_drain = 1'b0;
  logic [LW-1:0] alarm_thr = LW'(16);
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [HALF_W-1:0] wr_data = '0;
  logic wr_ready, rd_valid, full, empty, alarm, underflow;
  logic [2*HALF_W-1:0] rd_data;
  logic [LW-1:0] level;

  int n_checks = 0;
  int n_fail = 0;
  logic [HALF_W-1:0] q[$];
  bit m_under = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_fifo #(.HALF_W(HALF_W), .DEPTH_HW(DEPTH_HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rx_en(rx_en),
    .half_drain(half_drain), .alarm_thr(alarm_thr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .full(full), .empty(empty), .level(level), .alarm(alarm),
    .underflow(underflow)
  );

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_rd_valid();
    return clr_n && rx_en && (half_drain ? q.size() >= 1 : q.size() >= 2);
  endfunction

  function automatic logic [2*HALF_W-1:0] exp_rd_data();
    if (!exp_rd_valid()) return '0;
    if (half_drain) return {16'h0, q[0]};
    return {q[1], q[0]};
  endfunction

  // Apply inputs at negedge, compare, then advance the model to the next edge.
  task automatic step(bit cn, bit en, bit hd, bit wv, bit rr, int th, logic [HALF_W-1:0] wd);
    bit push, pop, both;
    @(negedge clk);
    clr_n = cn; rx_en = en; half_drain = hd; wr_valid = wv; rd_ready = rr;
    alarm_thr = LW'(th); wr_data = wd;
    #1;
    check("R2 wr_ready", wr_ready, clr_n && q.size() < DEPTH_HW);
    check("R3 full", full, q.size() == DEPTH_HW);
    check("R1 empty", empty, q.size() == 0);
    check("R7 alarm", alarm, q.size() > th);
    check(hd ? "R5 rd_valid" : (en ? "R4 rd_valid" : "R6 rd_valid"), rd_valid, exp_rd_valid());
    check(hd ? "R5/R10 rd_data" : "R4/R10 rd_data", rd_data, exp_rd_data());
    check("R8 underflow", underflow, m_under);
    push = wv && cn && q.size() < DEPTH_HW;
    pop = rr && exp_rd_valid();
    both = push && pop;
    check(both ? "R9 level" : "R2 level", level, q.size());
    if (!cn) begin
      q.delete();
      m_under = 1'b0;
    end else begin
      if (en && rr && !exp_rd_valid()) m_under = 1'b1;
      if (pop) begin
        void'(q.pop_front());
        if (!hd) void'(q.pop_front());
      end
      if (push) q.push_back(wd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset level", level, 0);
    check("R1 reset empty", empty, 1);
    check("R1 reset alarm", alarm, 0);
    check("R1 reset underflow", underflow, 0);
    @(negedge clk); rst_n = 1'b1;

    // R8: underflow on empty FIFO, R6: disabled read has no effect
    step(1, 0, 0, 0, 1, 16, 0);
    step(1, 1, 0, 0, 1, 16, 0);
    step(1, 1, 0, 0, 0, 16, 0);
    // R1: clear holds empty and drops underflow
    step(0, 0, 0, 1, 0, 16, 16'h1111);
    step(1, 0, 0, 0, 0, 16, 0);
    // fill past full with R7 threshold crossings (R3)
    for (int i = 0; i < DEPTH_HW + 4; i++)
      step(1, 0, 0, 1, 0, 16, HALF_W'(16'hA000 + i));
    step(1, 0, 0, 0, 0, DEPTH_HW - 1, 0);
    step(1, 0, 0, 0, 1, DEPTH_HW, 0);
    // R9: read and write at full, then word reads down to one odd halfword
    step(1, 1, 0, 1, 1, 16, 16'hBEEF);
    step(1, 0, 0, 1, 0, 16, 16'hC001);
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 1, 16, 0);
    // R5: half drain of leftover, then underflow in half mode
    step(1, 1, 1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int wbias = $urandom_range(10, 90);
      int rbias = $urandom_range(10, 90);
      for (int c = 0; c < 80; c++) begin
        bit cn = ($urandom_range(0, 299) != 0);
        bit en = ($urandom_range(0, 9) != 0);
        bit hd = ($urandom_range(0, 5) == 0);
        bit wv = ($urandom_range(0, 99) < wbias);
        bit rr = ($urandom_range(0, 99) < rbias);
        int th = $urandom_range(0, DEPTH_HW);
        step(cn, en, hd, wv, rr, th, HALF_W'($urandom));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule